// File: doc/BRIEF.md
# Interrupt-Capable Control/Status Register Slave

This block is a small register file that sits on a memory-mapped bus as a slave. It takes single full-word 32-bit reads and writes addressed by a 6-bit byte address. Each accepted read returns its data one clock later, marked by a separate one-cycle valid strobe. It holds an identification word, a general control word that it drives out to the surrounding logic, and three interrupt registers: a global enable, a per-source enable and a source status.

Hardware event pulses set status bits. Software clears a status bit by writing a 1 to it. A level interrupt output is formed from the status bits and both enable levels. The interrupt is independent of whatever transfer is on the bus at the time. All signals are synchronous to one clock, and the reset is active low.

Top module: `csr_irq_regs`

## Requirements
- R1: After reset the interrupt output, the read-valid strobe and the read data are 0. The control, global enable, per-source enable and status registers all read back 0.
- R2: Decode uses address bits [5:2] only, so bits [1:0] are ignored. Index 0 (byte 0x00) returns the parameter ID_VALUE and ignores writes. Index 1 (0x04) is a 32-bit read/write control word driven on ctrl. Index 2 (0x08) holds the global enable in bit 0. Index 3 (0x0C) holds the per-source enables in bits [NEVT-1:0]. Index 4 (0x10) holds the status in bits [NEVT-1:0]. Unimplemented bits read 0.
- R3: A read of any other index returns 0. A write to any other index changes no register.
- R4: A read request without a write request makes rvalid high for exactly the following cycle. In that cycle rdata holds the value the register had when the request was sampled. In every cycle where rvalid is low, rdata keeps its previous value.
- R5: If a read request and a write request are both high in the same cycle, only the write is performed and no rvalid pulse follows.
- R6: A high evt[i] sets status bit i. Writing a 1 to a status bit clears it. Writing a 0 leaves it unchanged. Status bits change for no other reason.
- R7: If an event and a clearing write hit the same status bit in the same cycle, the bit stays set.
- R8: irq is high exactly when the global enable is 1 and some status bit is set whose per-source enable is also set. It depends only on register state, not on the bus inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 6 | Byte address of the transfer |
| rd | input | 1 | Read request |
| wr | input | 1 | Write request |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid while rvalid is high |
| rvalid | output | 1 | One-cycle read data valid strobe |
| evt | input | NEVT | Hardware event pulses that set status bits |
| ctrl | output | 32 | Current value of the control register |
| irq | output | 1 | Level interrupt request |

## Verification
The hardest case to reach is a hardware event landing on a status bit in the same cycle that software writes a 1 to clear it. With that comes the check that the interrupt stays up through partial clears. Directed steps set up two pending sources and clear one. They write zeros and then fire an event together with the clear on the remaining bit. After that, a long random run with sparse events, accesses biased toward the interrupt registers and frequent read-plus-write collisions produces many more same-cycle collisions. Each one is compared with a bench model of the register state.

// File: rtl/csr_irq_regs.sv
module csr_irq_regs #(
  parameter int          NEVT     = 8,
  parameter logic [31:0] ID_VALUE = 32'h5253_0102
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [5:0]      addr,
  input  logic            rd,
  input  logic            wr,
  input  logic [31:0]     wdata,
  output logic [31:0]     rdata,
  output logic            rvalid,
  input  logic [NEVT-1:0] evt,
  output logic [31:0]     ctrl,
  output logic            irq
);
  localparam logic [3:0] IX_ID   = 4'd0;
  localparam logic [3:0] IX_CTRL = 4'd1;
  localparam logic [3:0] IX_GIE  = 4'd2;
  localparam logic [3:0] IX_IEN  = 4'd3;
  localparam logic [3:0] IX_STAT = 4'd4;

  logic [3:0]      idx;
  logic            gie;
  logic [NEVT-1:0] ien;
  logic [NEVT-1:0] status;
  logic [NEVT-1:0] clr;
  logic [31:0]     rmux;
  logic            rd_go;
  logic            unused_lo;

  assign idx       = addr[5:2];
  assign unused_lo = ^addr[1:0];
  assign rd_go     = rd && !wr;
  assign clr       = (wr && idx == IX_STAT) ? wdata[NEVT-1:0] : '0;
  assign irq       = gie && |(status & ien);

  always_comb begin
    case (idx)
      IX_ID:   rmux = ID_VALUE;
      IX_CTRL: rmux = ctrl;
      IX_GIE:  rmux = {31'b0, gie};
      IX_IEN:  rmux = 32'(ien);
      IX_STAT: rmux = 32'(status);
      default: rmux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl <= '0;
      gie  <= 1'b0;
      ien  <= '0;
    end else if (wr) begin
      if (idx == IX_CTRL) ctrl <= wdata;
      if (idx == IX_GIE)  gie  <= wdata[0];
      if (idx == IX_IEN)  ien  <= wdata[NEVT-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) status <= '0;
    else        status <= (status & ~clr) | evt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rvalid <= 1'b0;
      rdata  <= '0;
    end else begin
      rvalid <= rd_go;
      if (rd_go) rdata <= rmux;
    end
  end
endmodule

// File: rtl/csr_irq_regs_chk.sv
module csr_irq_regs_chk #(
  parameter int NEVT = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic [5:0]      addr,
  input logic            rd,
  input logic            wr,
  input logic [NEVT-1:0] evt,
  input logic [31:0]     rdata,
  input logic            rvalid,
  input logic            irq,
  input logic            gie,
  input logic [NEVT-1:0] ien,
  input logic [NEVT-1:0] status
);
  AST_RVALID_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !wr) |=> rvalid); // R4
  AST_NO_RVALID_WITHOUT_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd && !wr) |=> !rvalid); // R5
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rvalid |-> $stable(rdata)); // R4
  AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |=> ((status & $past(evt)) == $past(evt))); // R7
  AST_CLEAR_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(status) & ~status) != '0) |-> $past(wr && addr[5:2] == 4'd4)); // R6
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (!gie || (status & ien) == '0) |-> !irq); // R8
endmodule

bind csr_irq_regs csr_irq_regs_chk #(.NEVT(NEVT)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .rd(rd), .wr(wr), .evt(evt),
  .rdata(rdata), .rvalid(rvalid), .irq(irq), .gie(gie), .ien(ien), .status(status)
);

// File: tb/csr_irq_regs_bench.sv
module csr_irq_regs_bench;
  localparam int          NEVT = 8;
  localparam logic [31:0] IDV  = 32'h5253_0102;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [5:0]      addr = '0;
  logic            rd = 1'b0, wr = 1'b0;
  logic [31:0]     wdata = '0;
  logic [31:0]     rdata;
  logic            rvalid;
  logic [NEVT-1:0] evt = '0;
  logic [31:0]     ctrl;
  logic            irq;

  int checks = 0, errors = 0, cycles = 0;
  logic [31:0]     m_ctrl = '0, m_rdata = '0;
  logic            m_gie = 1'b0;
  logic [NEVT-1:0] m_ien = '0, m_st = '0;

  csr_irq_regs #(.NEVT(NEVT), .ID_VALUE(IDV)) u_csr_irq_regs (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rd(rd), .wr(wr), .wdata(wdata),
    .rdata(rdata), .rvalid(rvalid), .evt(evt), .ctrl(ctrl), .irq(irq));

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic logic [31:0] model_read(input logic [5:0] a);
    case (a[5:2])
      4'd0: return IDV;
      4'd1: return m_ctrl;
      4'd2: return {31'b0, m_gie};
      4'd3: return 32'(m_ien);
      4'd4: return 32'(m_st);
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic model_irq();
    return m_gie && |(m_st & m_ien);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic r, input logic w, input logic [5:0] a,
                      input logic [31:0] d, input logic [NEVT-1:0] e, input string tag);
    logic exp_rv;
    logic [NEVT-1:0] clr;
    @(negedge clk);
    rd = r; wr = w; addr = a; wdata = d; evt = e;
    exp_rv = r && !w;
    if (exp_rv) m_rdata = model_read(a);
    clr = '0;
    if (w) begin
      case (a[5:2])
        4'd1: m_ctrl = d;
        4'd2: m_gie  = d[0];
        4'd3: m_ien  = d[NEVT-1:0];
        4'd4: clr    = d[NEVT-1:0];
        default: ;
      endcase
    end
    m_st = (m_st & ~clr) | e;
    @(posedge clk); #1;
    chk(rvalid === exp_rv, r && w ? "R5 rvalid" : "R4 rvalid", 32'(rvalid), 32'(exp_rv));
    chk(rdata === m_rdata, exp_rv ? tag : "R4 rdata hold", rdata, m_rdata);
    chk(irq === model_irq(), "R8 irq", 32'(irq), 32'(model_irq()));
    chk(ctrl === m_ctrl, "R2 ctrl", ctrl, m_ctrl);
    @(negedge clk);
    rd = 1'b0; wr = 1'b0; evt = '0;
  endtask

  task automatic rdchk(input logic [5:0] a, input string tag);
    step(1'b1, 1'b0, a, 32'h0, '0, tag);
  endtask

  task automatic wrt(input logic [5:0] a, input logic [31:0] d, input logic [NEVT-1:0] e);
    step(1'b0, 1'b1, a, d, e, "R2 rdata");
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1;
    chk(irq === 1'b0 && rvalid === 1'b0 && rdata === 32'h0, "R1 reset outputs",
        {rdata[29:0], rvalid, irq}, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    rdchk(6'h04, "R1 ctrl reset");
    rdchk(6'h08, "R1 gie reset");
    rdchk(6'h0C, "R1 ien reset");
    rdchk(6'h10, "R1 status reset");
    rdchk(6'h00, "R2 id read");
    wrt(6'h00, 32'hFFFF_FFFF, '0);
    rdchk(6'h00, "R2 id read-only");
    wrt(6'h07, 32'hA5A5_5A5A, '0);
    rdchk(6'h05, "R2 low address bits ignored");
    wrt(6'h20, 32'hFFFF_FFFF, '0);
    wrt(6'h3C, 32'hFFFF_FFFF, '0);
    rdchk(6'h2B, "R3 unmapped reads zero");
    rdchk(6'h04, "R3 unmapped write left ctrl");
    rdchk(6'h08, "R3 unmapped write left gie");
    wrt(6'h10, 32'h0, 8'h05);
    rdchk(6'h10, "R6 events set status");
    wrt(6'h0C, 32'h0000_0004, '0);
    wrt(6'h08, 32'h0000_0001, '0);
    chk(irq === 1'b1, "R8 irq with both enables", 32'(irq), 32'h1);
    wrt(6'h10, 32'h0000_0001, '0);
    rdchk(6'h10, "R6 write-one clears bit");
    chk(irq === 1'b1, "R8 irq holds on partial clear", 32'(irq), 32'h1);
    wrt(6'h10, 32'h0, '0);
    rdchk(6'h10, "R6 write zero no change");
    wrt(6'h10, 32'h0000_0004, 8'h04);
    rdchk(6'h10, "R7 event beats clear");
    chk(irq === 1'b1, "R7 irq stays", 32'(irq), 32'h1);
    step(1'b1, 1'b1, 6'h10, 32'h0000_0004, '0, "R5 read+write");
    chk(irq === 1'b0, "R5 write done when read collides", 32'(irq), 32'h0);
    rdchk(6'h10, "R5 status cleared by write");
    wrt(6'h10, 32'h0, 8'h10);
    wrt(6'h0C, 32'h0000_0010, '0);
    chk(irq === 1'b1, "R8 enable pending source", 32'(irq), 32'h1);
    wrt(6'h08, 32'h0, '0);
    chk(irq === 1'b0, "R8 global enable gates", 32'(irq), 32'h0);
    for (int i = 0; i < 4000; i++) begin
      logic [5:0] a;
      logic [31:0] d;
      logic r, w;
      a = ($urandom % 4 == 0) ? 6'($urandom) : {1'b0, 3'(2 + $urandom % 3), 2'($urandom)};
      d = $urandom;
      r = ($urandom % 2) == 1;
      w = ($urandom % 3) == 0;
      step(r, w, a, d, NEVT'($urandom & $urandom & $urandom), "R2 random rdata");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule